// File: doc/BRIEF.md
# Sense-Reversing Barrier Unit

This block holds a fixed group of agents at a synchronization point until every one of them has arrived. Each agent pulses its arrival line once per episode. The unit counts the arrivals in a single shared counter, so simultaneous arrivals cannot corrupt it. When the count reaches the group size, the counter returns to zero and a global flag flips. Every agent that has arrived is then released in the same cycle.

Each agent owns a local sense bit. The bit inverts whenever an arrival from that agent is accepted. An agent is waiting while its sense bit differs from the global flag, and it is free while the two are equal. The flag is inverted once per episode, so no second clearing pass is needed before the barrier is used again. An agent that has just been released may arrive again in the very next cycle, and that arrival counts toward the next episode.

The group size is fixed when the unit is built. A per-agent release output goes high at the end of each episode. It stays high until that agent's next accepted arrival.

Top module: `sense_barrier`

## Requirements
- R1: After reset the global flag, every local sense bit, the arrival count and every release output are 0.
- R2: An arrival from an agent whose sense bit equals the global flag is accepted, and that agent's sense bit inverts on the next clock edge.
- R3: An arrival from an agent whose sense bit differs from the global flag (that agent is still waiting) is ignored. It changes neither the count nor that agent's sense bit.
- R4: All arrivals accepted in one cycle are counted in that cycle. Unless the episode completes, the count rises by exactly the number of accepted arrivals.
- R5: When the accepted arrivals bring the total to the group size, the count returns to 0 and the global flag inverts on the same edge. The new flag equals the new sense value of the last arriver.
- R6: On the edge that completes an episode, every release output goes high. Each one stays high until its agent's next accepted arrival, which clears it on the next edge.
- R7: After a completing edge every sense bit equals the global flag, so no agent is left waiting when the next episode can begin. An arrival in the cycle right after completion is accepted into the new episode.
- R8: The count is always less than the group size.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arrive_i | input | NUM_AGENTS | One arrival pulse per agent |
| release_o | output | NUM_AGENTS | Per-agent release, held until the agent's next arrival |
| sense_o | output | NUM_AGENTS | Local sense bit of each agent |
| flag_o | output | 1 | Global flag, inverted once per episode |
| count_o | output | $clog2(NUM_AGENTS+1) | Arrivals counted in the current episode |

## Verification
A sense bit stuck at the wrong value shows up one edge after the faulty arrival. The agent then either misses the release at the end of the episode or leaves early, and in both cases sense_o no longer matches flag_o. A miscounted arrival moves the completion by a cycle or more, so flag_o flips too early or too late in that same episode. An arrival that should have been dropped appears at once as a count one too high. The vector sequence covers single, simultaneous and duplicate arrivals, arrivals from agents that are still waiting, and arrivals back to back across episode boundaries. Each value is compared one edge after the stimulus.

// File: rtl/barrier_pkg.sv
package barrier_pkg;

    // State held for one agent
    typedef struct packed {
        logic sense;   // local sense bit
        logic rel;     // release indication
    } slot_state_t;

endpackage

// File: rtl/barrier_sense_slot.sv
module barrier_sense_slot
    import barrier_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arrive_i,
    input  logic flag_i,
    input  logic complete_i,
    output logic accept_o,
    output logic sense_o,
    output logic release_o
);

    slot_state_t st_d, st_q;
    logic        accept;

    always_comb begin
        st_d   = st_q;
        // an agent is free to arrive only when its sense matches the flag
        accept = arrive_i && (st_q.sense == flag_i);
        if (accept) begin
            st_d.sense = ~st_q.sense;
        end
        if (complete_i) begin
            st_d.rel = 1'b1;
        end else if (accept) begin
            st_d.rel = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign accept_o  = accept;
    assign sense_o   = st_q.sense;
    assign release_o = st_q.rel;

    // R3: a waiting agent keeps its sense bit whatever it drives
    p_waiting_sense_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sense != flag_i) |=> (st_q.sense == $past(st_q.sense)));

    // R2: an accepted arrival inverts the sense bit
    p_accept_toggles_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (arrive_i && (st_q.sense == flag_i)) |=> (st_q.sense != $past(st_q.sense)));

    // R6: an arrival that does not complete the episode drops release
    p_release_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !complete_i) |=> !st_q.rel);

    // R6: completion raises release
    p_release_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        complete_i |=> st_q.rel);

endmodule

// File: rtl/barrier_episode_ctrl.sv
module barrier_episode_ctrl #(
    parameter  int NUM_AGENTS = 4,
    localparam int CNT_W      = $clog2(NUM_AGENTS + 1),
    localparam int SUM_W      = $clog2(2 * NUM_AGENTS) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_AGENTS-1:0] accept_i,
    output logic                  complete_o,
    output logic                  flag_o,
    output logic [CNT_W-1:0]      count_o
);

    typedef struct packed {
        logic             flag;
        logic [CNT_W-1:0] count;
    } episode_t;

    episode_t         ep_d, ep_q;
    logic [SUM_W-1:0] total;
    logic             complete;

    always_comb begin
        // every accepted arrival of this cycle is added at once
        total = SUM_W'(ep_q.count);
        for (int i = 0; i < NUM_AGENTS; i++) begin
            total = total + SUM_W'(accept_i[i]);
        end
        complete = (total == SUM_W'(NUM_AGENTS));
        ep_d     = ep_q;
        if (complete) begin
            ep_d.count = '0;
            ep_d.flag  = ~ep_q.flag;
        end else begin
            ep_d.count = CNT_W'(total);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ep_q <= '0;
        end else begin
            ep_q <= ep_d;
        end
    end

    assign complete_o = complete;
    assign flag_o     = ep_q.flag;
    assign count_o    = ep_q.count;

    // R8: count stays below the group size
    p_count_below_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ep_q.count) < NUM_AGENTS);

    // R4: without completion the count grows by the accepted arrivals
    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !complete |=> (int'(ep_q.count) == int'($past(ep_q.count)) + $countones($past(accept_i))));

    // R5: completion inverts the flag and zeroes the count
    p_flag_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> ((ep_q.flag != $past(ep_q.flag)) && (ep_q.count == '0)));

    // R5: the flag moves only on completion
    p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !complete |=> $stable(ep_q.flag));

endmodule

// File: rtl/sense_barrier.sv
module sense_barrier #(
    parameter  int NUM_AGENTS = 4,
    localparam int CNT_W      = $clog2(NUM_AGENTS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_AGENTS-1:0] arrive_i,
    output logic [NUM_AGENTS-1:0] release_o,
    output logic [NUM_AGENTS-1:0] sense_o,
    output logic                  flag_o,
    output logic [CNT_W-1:0]      count_o
);

    logic [NUM_AGENTS-1:0] accept;
    logic                  complete;
    logic                  flag;

    for (genvar g = 0; g < NUM_AGENTS; g++) begin : g_slot
        barrier_sense_slot i_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .arrive_i   (arrive_i[g]),
            .flag_i     (flag),
            .complete_i (complete),
            .accept_o   (accept[g]),
            .sense_o    (sense_o[g]),
            .release_o  (release_o[g])
        );
    end

    barrier_episode_ctrl #(
        .NUM_AGENTS (NUM_AGENTS)
    ) i_episode (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .complete_o (complete),
        .flag_o     (flag),
        .count_o    (count_o)
    );

    assign flag_o = flag;

    // R7: nobody is still waiting once an episode completes
    p_all_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> (sense_o == {NUM_AGENTS{flag_o}}));

    // R6: a completing edge raises every release output
    p_release_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> (release_o == {NUM_AGENTS{1'b1}}));

endmodule

// File: tb/test_sense_barrier.sv
module test_sense_barrier;

    localparam int P = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [P-1:0] arrive = '0;
    logic [P-1:0] release_o;
    logic [P-1:0] sense_o;
    logic         flag_o;
    logic [2:0]   count_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    sense_barrier #(.NUM_AGENTS(P)) i_sense_barrier (
        .clk       (clk),
        .rst_n     (rst_n),
        .arrive_i  (arrive),
        .release_o (release_o),
        .sense_o   (sense_o),
        .flag_o    (flag_o),
        .count_o   (count_o)
    );

    // {arrive[3:0], count[2:0], flag, sense[3:0], release[3:0]} after one edge
    localparam logic [15:0] VEC [0:10] = '{
        16'b0001_001_0_0001_0000,  // agent 0 arrives
        16'b0001_001_0_0001_0000,  // R3: agent 0 repeats while waiting
        16'b0110_011_0_0111_0000,  // two arrive together
        16'b0000_011_0_0111_0000,  // idle
        16'b1000_000_1_1111_1111,  // last arriver completes
        16'b0011_010_1_1100_1100,  // next episode starts at once
        16'b1111_000_0_0000_1111,  // R3: waiting 0,1 ignored; 2,3 complete
        16'b1111_000_1_1111_1111,  // everyone at once
        16'b0100_001_1_1011_1011,
        16'b0100_001_1_1011_1011,  // R3: duplicate dropped
        16'b1011_000_0_0000_1111   // remaining three complete
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [P-1:0] a);
        @(negedge clk);
        arrive = a;
        @(posedge clk);
        #1;
        arrive = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 flag", 16'(flag_o), 16'd0);
        check("R1 sense", 16'(sense_o), 16'd0);
        check("R1 count", 16'(count_o), 16'd0);
        check("R1 release", 16'(release_o), 16'd0);
        rst_n = 1'b1;

        for (int v = 0; v < 11; v++) begin
            step(VEC[v][15:12]);
            check("R4 count", 16'(count_o), 16'(VEC[v][11:9]));
            check("R5 flag", 16'(flag_o), 16'(VEC[v][8]));
            check("R2 sense", 16'(sense_o), 16'(VEC[v][7:4]));
            check("R6 release", 16'(release_o), 16'(VEC[v][3:0]));
            check("R8 count below size", 16'(count_o < 3'(P)), 16'd1);
        end

        // R7: all agents free after the completion above
        check("R7 sense equals flag", 16'(sense_o), 16'({P{flag_o}}));

        // R6: release held across idle cycles
        repeat (3) step('0);
        check("R6 release held", 16'(release_o), 16'hF);

        // R7: arrival right after completion goes into the new episode
        step(4'b1111);
        check("R7 flag after full group", 16'(flag_o), 16'd1);
        step(4'b1000);
        check("R7 back-to-back count", 16'(count_o), 16'd1);
        check("R7 back-to-back sense", 16'(sense_o), 16'b0111);
        check("R6 release cleared on arrival", 16'(release_o), 16'b0111);

        // R3: waiting agent 3 pulses again, nothing moves
        step(4'b1000);
        check("R3 count unchanged", 16'(count_o), 16'd1);
        check("R3 sense unchanged", 16'(sense_o), 16'b0111);

        // R1: reset in mid-episode
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 flag mid reset", 16'(flag_o), 16'd0);
        check("R1 sense mid reset", 16'(sense_o), 16'd0);
        check("R1 count mid reset", 16'(count_o), 16'd0);
        check("R1 release mid reset", 16'(release_o), 16'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule